// File: doc/BRIEF.md
# Fractional baud clock generator

This block turns a fast system clock into two single-cycle strobes for a serial engine: a bit-slice (oversampling) tick and a baud tick. An integer prescaler first divides the clock by PDIV+1. Each prescaler strobe then adds a 10-bit STEP value to a modulo-1024 phase accumulator, and every carry out of that accumulator is one bit-slice tick. The slice rate is therefore STEP/(1024·(PDIV+1)) of the system clock, so rates that are not an integer fraction of it can still be approximated closely. A small oversample counter passes on every (DCQT+1)-th slice tick as the baud tick.

The settings are held steady by the surrounding logic. Whenever enable is low, or any setting differs from its value in the previous cycle, the whole chain returns to its start state. The first cycle after that cleanly begins a new tick sequence. Serialisation and the choice of setting values lie outside the block.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst_n is low, slice_tick and baud_tick stay low. Reset clears every counter, the accumulator and the held copy of the settings.
- R2: Number the running cycles t = 0, 1, 2, ... from the first cycle in which enable is high and the settings equal those of the previous cycle. A slice tick can occur only in a cycle where t+1 is a multiple of PDIV+1. With PDIV = 0 this is every cycle.
- R3: The prescaler strobe at t+1 = j·(PDIV+1) is the j-th strobe. On that strobe, slice_tick is high exactly when floor(j·STEP/1024) > floor((j−1)·STEP/1024). STEP is 10 bits wide (0..1023) and the accumulator wraps modulo 1024.
- R4: With STEP = 0, slice_tick and baud_tick never go high.
- R5: baud_tick is high only together with slice_tick, and only on the m-th slice tick of a run where m is a multiple of DCQT+1. DCQT is the 4-bit oversample field.
- R6: With DCQT = 0, every slice tick is also a baud tick.
- R7: While enable is low, both ticks stay low and all state is cleared. Raising enable again restarts the sequence at t = 0.
- R8: In a cycle where prescale, step or oversample differs from its previous-cycle value, both ticks are low, even if a tick would otherwise have fallen in that cycle. The sequence restarts at t = 0 in the next cycle.
- R9: With PDIV = 2, STEP = 59 and DCQT = 15, and a 32 MHz system clock, 49152 cycles hold exactly 944 slice ticks and 59 baud ticks. That is a baud rate within 0.03 % of 38400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low clears all state |
| prescale | input | PRE_W (10) | Integer prescaler setting PDIV, divides by PDIV+1 |
| step | input | STEP_W (10) | Fractional step added per prescaler strobe |
| oversample | input | OS_W (4) | Oversample setting DCQT, DCQT+1 slices per bit |
| slice_tick | output | 1 | Single-cycle bit-slice strobe |
| baud_tick | output | 1 | Single-cycle baud strobe |

## Verification
A settings change and a due tick can land in the same cycle, and the restart must win. The bench runs PDIV = 0, STEP = 512, DCQT = 1 up to the cycle just before the second slice tick, which is also a baud tick. It then alters STEP in that very cycle, checks that both strobes stay low there, and checks that the tick pattern for the new setting starts from t = 0 in the next cycle. The sweep separately judges every cycle in which a slice tick and a baud wrap coincide, against the arithmetic model.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

   localparam int unsigned FBG_PRE_W_DEF  = 10;
   localparam int unsigned FBG_STEP_W_DEF = 10;
   localparam int unsigned FBG_OS_W_DEF   = 4;
   localparam int unsigned FBG_MAX_W      = 16;

   // True when a wrapping counter has reached (or passed) its terminal value.
   function automatic logic fbg_at_limit(input logic [31:0] cnt, input logic [31:0] lim);
      return (cnt >= lim);
   endfunction

endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler
   import fbg_pkg::*;
#(
   parameter int unsigned W = 10
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         en_o
);

   logic [W-1:0] cnt;
   logic         at_end;

   assign at_end = fbg_at_limit(32'(cnt), 32'(limit));
   assign en_o   = !clr && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (at_end)  cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   // After a strobe the division period begins afresh.
   p_pre_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_o |=> (cnt == '0));

endmodule

// File: rtl/fbg_step_acc.sv
module fbg_step_acc #(
   parameter int unsigned W = 10
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] step,
   output logic         carry_o
);

   logic [W-1:0] acc;
   logic [W:0]   sum;

   assign sum     = {1'b0, acc} + {1'b0, step};
   assign carry_o = adv && sum[W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (clr)  acc <= '0;
      else if (adv)  acc <= sum[W-1:0];
   end

   // A zero step leaves the phase untouched (R4).
   p_zero_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && step == '0) |=> $stable(acc));

   // Phase moves only on a prescaler strobe (R3).
   p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(acc));

endmodule

// File: rtl/fbg_os_count.sv
module fbg_os_count
   import fbg_pkg::*;
#(
   parameter int unsigned W = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] limit,
   output logic         wrap_o
);

   logic [W-1:0] cnt;
   logic         at_end;

   assign at_end = fbg_at_limit(32'(cnt), 32'(limit));
   assign wrap_o = adv && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (clr)      cnt <= '0;
      else if (adv) begin
         if (at_end)     cnt <= '0;
         else            cnt <= cnt + 1'b1;
      end
   end

   // A baud strobe starts a new bit of slices (R5).
   p_os_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt == '0));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import fbg_pkg::*;
#(
   parameter int unsigned PRE_W          = FBG_PRE_W_DEF,
   parameter int unsigned STEP_W         = FBG_STEP_W_DEF,
   parameter int unsigned OS_W           = FBG_OS_W_DEF,
   parameter bit          RESTART_ON_CFG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [PRE_W-1:0]  prescale,
   input  logic [STEP_W-1:0] step,
   input  logic [OS_W-1:0]   oversample,
   output logic              slice_tick,
   output logic              baud_tick
);

   localparam int unsigned CFG_W = PRE_W + STEP_W + OS_W;

   generate
      if (PRE_W < 1 || PRE_W > FBG_MAX_W) begin : g_bad_pre
         $error("frac_baud_gen: PRE_W out of range");
      end
      if (STEP_W < 2 || STEP_W > FBG_MAX_W) begin : g_bad_step
         $error("frac_baud_gen: STEP_W out of range");
      end
      if (OS_W < 1 || OS_W > FBG_MAX_W) begin : g_bad_os
         $error("frac_baud_gen: OS_W out of range");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_now;
   logic             cfg_changed;
   logic             restart;
   logic             pre_en;
   logic             slice_int;
   logic             baud_int;

   assign cfg_now = {prescale, step, oversample};

   generate
      if (RESTART_ON_CFG) begin : g_track
         logic [CFG_W-1:0] cfg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q <= '0;
            else        cfg_q <= cfg_now;
         end
         assign cfg_changed = (cfg_q != cfg_now);
      end else begin : g_free
         assign cfg_changed = 1'b0;
      end
   endgenerate

   assign restart = !enable || cfg_changed;

   fbg_prescaler #(.W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .limit (prescale),
      .en_o  (pre_en)
   );

   fbg_step_acc #(.W(STEP_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart),
      .adv     (pre_en),
      .step    (step),
      .carry_o (slice_int)
   );

   fbg_os_count #(.W(OS_W)) u_os (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (restart),
      .adv    (slice_int),
      .limit  (oversample),
      .wrap_o (baud_int)
   );

   assign slice_tick = slice_int;
   assign baud_tick  = baud_int;

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!slice_tick && !baud_tick));

   p_cfg_edge_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_changed |-> (!slice_tick && !baud_tick));

   p_baud_in_slice_r5: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> slice_tick);

   p_zero_step_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step == '0) |-> !slice_tick);

endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       enable;
   logic [9:0] prescale;
   logic [9:0] step;
   logic [3:0] oversample;
   logic       slice_tick;
   logic       baud_tick;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   frac_baud_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .prescale   (prescale),
      .step       (step),
      .oversample (oversample),
      .slice_tick (slice_tick),
      .baud_tick  (baud_tick)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Arithmetic expectation for running cycle t.
   function automatic void expect_at(input int t, input int pd, input int st, input int dq,
                                     output bit s, output bit b);
      int per;
      int j;
      int m1;
      int m0;
      per = pd + 1;
      s = 1'b0;
      b = 1'b0;
      if (((t + 1) % per) == 0) begin
         j  = (t + 1) / per;
         m1 = (j * st) / 1024;
         m0 = ((j - 1) * st) / 1024;
         s  = (m1 != m0);
         b  = s && ((m1 % (dq + 1)) == 0);
      end
   endfunction

   // One idle cycle with the new settings loaded, then enable goes high.
   task automatic start_cfg(input int pd, input int st, input int dq);
      @(posedge clk);
      #1;
      enable     = 1'b0;
      prescale   = 10'(pd);
      step       = 10'(st);
      oversample = 4'(dq);
      @(negedge clk);
      check(!slice_tick && !baud_tick, "R7", "ticks while disabled",
            int'({slice_tick, baud_tick}), 0);
      @(posedge clk);
      #1;
      enable = 1'b1;
   endtask

   task automatic compare_run(input int pd, input int st, input int dq, input int ncyc);
      int  bad_s = 0;
      int  bad_b = 0;
      int  off_phase = 0;
      int  first_t = -1;
      int  act_s = 0;
      int  exp_s = 0;
      int  act_b = 0;
      int  exp_b = 0;
      bit  es;
      bit  eb;
      string rs;
      string rb;
      for (int t = 0; t < ncyc; t++) begin
         @(negedge clk);
         expect_at(t, pd, st, dq, es, eb);
         if (slice_tick && (((t + 1) % (pd + 1)) != 0)) off_phase++;
         if (slice_tick != es || baud_tick != eb) begin
            if (slice_tick != es) bad_s++;
            if (baud_tick != eb)  bad_b++;
            if (first_t < 0) begin
               first_t = t;
               act_s = int'(slice_tick); exp_s = int'(es);
               act_b = int'(baud_tick);  exp_b = int'(eb);
            end
         end
      end
      rs = (st == 0) ? "R4" : "R3";
      rb = (st == 0) ? "R4" : ((dq == 0) ? "R6" : "R5");
      check(off_phase == 0, "R2", $sformatf("slice off prescaler phase pd=%0d st=%0d", pd, st),
            off_phase, 0);
      check(bad_s == 0, rs, $sformatf("slice_tick pd=%0d st=%0d dq=%0d t=%0d", pd, st, dq, first_t),
            act_s, exp_s);
      check(bad_b == 0, rb, $sformatf("baud_tick pd=%0d st=%0d dq=%0d t=%0d", pd, st, dq, first_t),
            act_b, exp_b);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int pds[4] = '{0, 1, 2, 5};
      int sts[5] = '{0, 1, 59, 512, 1023};
      int dqs[3] = '{0, 3, 15};
      int ns;
      int nb;
      real rate;
      real err;

      // R1: reset holds everything quiet even with an aggressive setting.
      rst_n = 1'b0;
      enable = 1'b1;
      prescale = 10'd0;
      step = 10'd1023;
      oversample = 4'd0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(!slice_tick && !baud_tick, "R1", "ticks during reset",
               int'({slice_tick, baud_tick}), 0);
      end
      enable = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!slice_tick && !baud_tick, "R1", "ticks after reset release",
            int'({slice_tick, baud_tick}), 0);

      // R2..R6: sweep of prescale, step and oversample.
      foreach (pds[i]) foreach (sts[k]) foreach (dqs[m]) begin
         start_cfg(pds[i], sts[k], dqs[m]);
         compare_run(pds[i], sts[k], dqs[m], 300);
      end

      // R8: settings change exactly in the cycle of a due slice+baud tick.
      start_cfg(0, 512, 1);
      compare_run(0, 512, 1, 3);
      @(posedge clk);
      #1;
      step = 10'd513;
      @(negedge clk);
      check(!slice_tick && !baud_tick, "R8", "ticks in settings-change cycle",
            int'({slice_tick, baud_tick}), 0);
      compare_run(0, 513, 1, 60);

      // R7: enable dropped mid-run, then the sequence restarts from t = 0.
      start_cfg(1, 700, 2);
      compare_run(1, 700, 2, 21);
      @(posedge clk);
      #1;
      enable = 1'b0;
      ns = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (slice_tick || baud_tick) ns++;
      end
      check(ns == 0, "R7", "ticks while enable low", ns, 0);
      @(posedge clk);
      #1;
      enable = 1'b1;
      compare_run(1, 700, 2, 100);

      // R9: 38400 baud from 32 MHz with 16x oversampling.
      start_cfg(2, 59, 15);
      ns = 0;
      nb = 0;
      for (int t = 0; t < 49152; t++) begin
         @(negedge clk);
         if (slice_tick) ns++;
         if (baud_tick)  nb++;
      end
      check(ns == 944, "R9", "slice ticks in 49152 cycles", ns, 944);
      check(nb == 59, "R9", "baud ticks in 49152 cycles", nb, 59);
      rate = real'(nb) / 49152.0 * 32.0e6;
      err  = (rate - 38400.0) / 38400.0;
      if (err < 0.0) err = -err;
      check(err < 0.0003, "R9", "baud rate error in ppm", int'(err * 1.0e6), 300);

      finish_run();
   end

endmodule